// File: doc/BRIEF.md
# DMA Channel Control and Status Register Window

This block holds the software-visible registers of one DMA channel: a control/status word, a transfer address word, and two general storage words (a byte count and a base address), all in a four-word window selected by byte-address bits [3:2]. Software reaches the window through full 32-bit reads and writes. The control word drives three signals towards the attached peripheral: a gated interrupt, a one-cycle reset pulse, and a DMA-enable level. The peripheral's own interrupt request comes in on a level input, and its edges set or clear a pending flag in the control word.

The block moves no data itself. Its only datapath action is on the address word, which advances by a byte count each time the transfer engine pulses the advance input. Some control bits cannot be changed by software. The version field always reads as a fixed pattern. The drain bit is forced by a write of zero and cleared by an explicit request. A write to the address word sets a sticky loaded flag.

Top module: `dma_csr_window`

## Requirements
- R1: After reset the control word (word 0) reads 0xA0000000, words 1, 2 and 3 read 0, and irq_out, periph_rst and dma_en are low.
- R2: A read with rd_en returns the word selected by bus_addr[3:2] on rdata, with rvalid high, one clock later. Word 0 is control, word 1 is address, word 2 is count, word 3 is base. Words 2 and 3 return the last value written to them.
- R3: On a control write, the bits under mask 0xFE000007 (bits 31..25 and 2..0) keep their previous values, the other bits take the written value, and 0xA0000000 is ORed in, so bits 31..28 always read 0xA.
- R4: irq_out is high exactly when control bit 0 (pending) and bit 4 (interrupt enable) are both set. A control write that changes bit 4 updates irq_out one clock after the write.
- R5: A rising edge on periph_irq sets control bit 0, and a falling edge clears it, one clock after the edge is sampled. If an edge and a control write fall in the same cycle, the edge decides bit 0.
- R6: A control write with bit 7 set raises periph_rst for exactly one clock, starting one clock after the write.
- R7: When bit 7 is clear, a control write with bit 6 set stores bit 6 as 0, and a control write of exactly 0 stores bit 6 as 1. When bit 7 is set, bit 6 is stored as written.
- R8: A write to word 1 sets control bit 26 (loaded). Later control writes leave that bit unchanged, because it lies under the read-only mask.
- R9: dma_en equals control bit 9 and changes only when a control write changes that bit.
- R10: A one-cycle pulse on adv_valid adds adv_len to word 1. If a write to word 1 happens in the same cycle, the written value is stored and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address in the window; bits [3:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | rdata valid, one clock after rd_en |
| periph_irq | input | 1 | Interrupt request level from the peripheral |
| adv_valid | input | 1 | Advance the address word by adv_len |
| adv_len | input | 16 | Byte count for the advance |
| irq_out | output | 1 | Gated interrupt output |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en | output | 1 | DMA enable level to the peripheral |

## Verification
The hardest case to reach from the ports is a pending interrupt that becomes visible or hidden only through enable writes while periph_irq stays high. The stimulus raises periph_irq while the enable bit is clear. It then toggles the enable with writes that also change an unrelated bit, and only after that lets periph_irq fall. This separates re-evaluation at write time from edge handling. The bench also collides an advance pulse with an address write, and follows a loaded-flag set with a control write of zero, to show that the masked bits keep their values when the drain rule applies.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int          CSR_W     = 32;
  localparam logic [31:0] RO_MASK   = 32'hFE00_0007;
  localparam logic [31:0] VER_BITS  = 32'hA000_0000;
  localparam int          B_PEND    = 0;
  localparam int          B_IEN     = 4;
  localparam int          B_DRAIN   = 6;
  localparam int          B_PRST    = 7;
  localparam int          B_DEN     = 9;
  localparam int          B_LOADED  = 26;
  localparam int          WORD_CTRL = 0;
  localparam int          WORD_ADDR = 1;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [CSR_W-1:0] wdata,
  input  logic             set_loaded,
  input  logic             pend_set,
  input  logic             pend_clr,
  output logic [CSR_W-1:0] ctrl_q,
  output logic             pend_d,
  output logic             ien_d,
  output logic             periph_rst,
  output logic             dma_en
);
  logic [CSR_W-1:0] wval;
  logic [CSR_W-1:0] merged;
  logic [CSR_W-1:0] ctrl_d;

  // Drain rule: reset request wins, then explicit drain clears, then zero sets.
  always_comb begin
    wval = wdata;
    if (wdata[B_PRST]) begin
      wval = wdata;
    end else if (wdata[B_DRAIN]) begin
      wval[B_DRAIN] = 1'b0;
    end else if (wdata == '0) begin
      wval[B_DRAIN] = 1'b1;
    end
    merged = (ctrl_q & RO_MASK) | (wval & ~RO_MASK) | VER_BITS;
  end

  always_comb begin
    ctrl_d = wr_ctrl ? merged : ctrl_q;
    if (set_loaded) ctrl_d[B_LOADED] = 1'b1;
    if (pend_set)      ctrl_d[B_PEND] = 1'b1;
    else if (pend_clr) ctrl_d[B_PEND] = 1'b0;
  end

  assign pend_d = ctrl_d[B_PEND];
  assign ien_d  = ctrl_d[B_IEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= VER_BITS;
      periph_rst <= 1'b0;
      dma_en     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      periph_rst <= wr_ctrl & wdata[B_PRST];
      dma_en     <= ctrl_d[B_DEN];
    end
  end
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq (
  input  logic clk,
  input  logic rst,
  input  logic periph_irq,
  input  logic pend_d,
  input  logic ien_d,
  output logic pend_set,
  output logic pend_clr,
  output logic irq_prev,
  output logic irq_out
);
  assign pend_set = periph_irq & ~irq_prev;
  assign pend_clr = ~periph_irq & irq_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      irq_prev <= periph_irq;
      irq_out  <= pend_d & ien_d;
    end
  end
endmodule

// File: rtl/dma_csr_addr.sv
module dma_csr_addr #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv_valid,
  input  logic [LEN_W-1:0]  adv_len,
  output logic [DATA_W-1:0] addr_q
);
  localparam int PAD_W = DATA_W - LEN_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= wdata;
    end else if (adv_valid) begin
      addr_q <= addr_q + {{PAD_W{1'b0}}, adv_len};
    end
  end
endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]                rdata,
  output logic                             rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= words[sel];
    end
  end
endmodule

// File: rtl/dma_csr_window.sv
module dma_csr_window
  import dma_csr_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int LEN_W     = 16,
  localparam int SEL_W    = $clog2(NUM_WORDS),
  localparam int ADDR_W   = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CSR_W-1:0]  wdata,
  output logic [CSR_W-1:0]  rdata,
  output logic              rvalid,
  input  logic              periph_irq,
  input  logic              adv_valid,
  input  logic [LEN_W-1:0]  adv_len,
  output logic              irq_out,
  output logic              periph_rst,
  output logic              dma_en
);
  logic [SEL_W-1:0] sel;
  logic             unused_byte_lanes;
  logic             wr_ctrl, wr_addr;
  logic             pend_set, pend_clr, pend_d, ien_d, irq_prev;
  logic [CSR_W-1:0] ctrl_q, addr_q;
  logic [NUM_WORDS-1:0][CSR_W-1:0] words;

  assign sel               = bus_addr[ADDR_W-1:2];
  assign unused_byte_lanes = ^bus_addr[1:0];
  assign wr_ctrl           = wr_en && (sel == SEL_W'(WORD_CTRL));
  assign wr_addr           = wr_en && (sel == SEL_W'(WORD_ADDR));

  dma_csr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .set_loaded(wr_addr), .pend_set(pend_set), .pend_clr(pend_clr),
    .ctrl_q(ctrl_q), .pend_d(pend_d), .ien_d(ien_d),
    .periph_rst(periph_rst), .dma_en(dma_en)
  );

  dma_csr_irq u_irq (
    .clk(clk), .rst(rst), .periph_irq(periph_irq),
    .pend_d(pend_d), .ien_d(ien_d),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .irq_prev(irq_prev), .irq_out(irq_out)
  );

  dma_csr_addr #(.DATA_W(CSR_W), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wdata(wdata),
    .adv_valid(adv_valid), .adv_len(adv_len), .addr_q(addr_q)
  );

  assign words[WORD_CTRL] = ctrl_q;
  assign words[WORD_ADDR] = addr_q;

  // Plain storage for the remaining words of the window.
  for (genvar k = 2; k < NUM_WORDS; k++) begin : g_plain
    logic [CSR_W-1:0] store_q;
    always_ff @(posedge clk) begin
      if (rst) store_q <= '0;
      else if (wr_en && (sel == SEL_W'(k))) store_q <= wdata;
    end
    assign words[k] = store_q;
  end

  dma_csr_rdmux #(.DATA_W(CSR_W), .NUM_WORDS(NUM_WORDS)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .words(words),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/dma_csr_window_chk.sv
module dma_csr_window_chk #(
  parameter int NUM_WORDS = 4,
  parameter int LEN_W     = 16,
  localparam int SEL_W    = $clog2(NUM_WORDS),
  localparam int ADDR_W   = SEL_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       wdata,
  input logic              periph_irq,
  input logic              irq_prev,
  input logic              adv_valid,
  input logic [LEN_W-1:0]  adv_len,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       addr_q,
  input logic              irq_out,
  input logic              periph_rst,
  input logic              dma_en
);
  logic [SEL_W-1:0] csel;
  assign csel = bus_addr[ADDR_W-1:2];

  p_version_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[31:28] == 4'hA);

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    irq_out == (ctrl_q[0] && ctrl_q[4]));

  p_pend_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (periph_irq && !irq_prev) |=> ctrl_q[0]);

  p_pend_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!periph_irq && irq_prev) |=> !ctrl_q[0]);

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    periph_rst |=> !periph_rst);

  p_rst_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csel == '0 && wdata[7]) |=> periph_rst);

  p_loaded_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csel == SEL_W'(1)) |=> ctrl_q[26]);

  p_dmaen_r9: assert property (@(posedge clk) disable iff (rst)
    dma_en == ctrl_q[9]);

  p_advance_r10: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !(wr_en && csel == SEL_W'(1)))
      |=> addr_q == $past(addr_q) + 32'($past(adv_len)));
endmodule

bind dma_csr_window dma_csr_window_chk #(.NUM_WORDS(NUM_WORDS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .bus_addr(bus_addr), .wdata(wdata),
  .periph_irq(periph_irq), .irq_prev(irq_prev), .adv_valid(adv_valid),
  .adv_len(adv_len), .ctrl_q(ctrl_q), .addr_q(addr_q), .irq_out(irq_out),
  .periph_rst(periph_rst), .dma_en(dma_en)
);

// File: tb/dma_csr_window_tb.sv
module dma_csr_window_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        periph_irq = 1'b0;
  logic        adv_valid = 1'b0;
  logic [15:0] adv_len = '0;
  logic        irq_out, periph_rst, dma_en;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct { logic [31:0] d; string tag; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  dma_csr_window u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_addr(bus_addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .periph_irq(periph_irq),
    .adv_valid(adv_valid), .adv_len(adv_len), .irq_out(irq_out),
    .periph_rst(periph_rst), .dma_en(dma_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; bus_addr = {w, 2'b00}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected word for the monitor.
  task automatic rd(input logic [1:0] w, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    rd_en = 1'b1; bus_addr = {w, 2'b00};
    e.d = exp; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: compares each returned word against the queue head.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (expq.size() == 0) begin
        check("R2 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(e.tag, rdata, e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 periph_rst", {31'd0, periph_rst}, 32'd0);
    check("R1 dma_en", {31'd0, dma_en}, 32'd0);
    rd(2'd0, 32'hA000_0000, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 addr");
    rd(2'd2, 32'h0, "R1 count");
    rd(2'd3, 32'h0, "R1 base");

    // R2 plain words
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'hCAFE_F00D);
    rd(2'd2, 32'h1234_5678, "R2 count");
    rd(2'd3, 32'hCAFE_F00D, "R2 base");

    // R3/R6/R7/R9 all ones: reset pulse, drain kept, masked bits held
    wr(2'd0, 32'hFFFF_FFFF);
    check("R6 pulse high", {31'd0, periph_rst}, 32'd1);
    check("R9 dma_en set", {31'd0, dma_en}, 32'd1);
    check("R4 no pending", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, periph_rst}, 32'd0);
    rd(2'd0, 32'hA1FF_FFF8, "R3 R7 ctrl all ones");

    // R7 drain request clears, R9 dma_en drops
    wr(2'd0, 32'h0000_0050);
    check("R9 dma_en clear", {31'd0, dma_en}, 32'd0);
    check("R6 no pulse", {31'd0, periph_rst}, 32'd0);
    rd(2'd0, 32'hA000_0010, "R7 drain cleared");

    // R7 zero write sets drain
    wr(2'd0, 32'h0);
    rd(2'd0, 32'hA000_0040, "R7 zero sets drain");

    // R5 rising edge with enable off, R4 gating
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    check("R4 masked pending", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'hA000_0041, "R5 rise sets pending");
    wr(2'd0, 32'h0000_0010);
    check("R4 enable shows pending", {31'd0, irq_out}, 32'd1);
    wr(2'd0, 32'h0000_0100);
    check("R4 disable hides pending", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'hA000_0101, "R3 pending held over write");
    wr(2'd0, 32'h0000_0010);
    check("R4 re-enable", {31'd0, irq_out}, 32'd1);
    @(negedge clk); periph_irq = 1'b0;
    @(negedge clk);
    check("R5 fall clears irq", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'hA000_0010, "R5 fall clears pending");

    // R3 pending bit not writable
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, 32'hA000_0000, "R3 pending read-only");

    // R9 repeated set keeps level
    wr(2'd0, 32'h0000_0200);
    check("R9 set", {31'd0, dma_en}, 32'd1);
    wr(2'd0, 32'h0000_0200);
    check("R9 hold", {31'd0, dma_en}, 32'd1);

    // R8 loaded flag
    wr(2'd1, 32'h0000_1000);
    rd(2'd0, 32'hA400_0200, "R8 loaded set");
    rd(2'd1, 32'h0000_1000, "R8 addr value");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'hA400_0040, "R8 loaded survives ctrl write");
    check("R9 cleared by zero", {31'd0, dma_en}, 32'd0);

    // R10 advance, then collision with a write
    @(negedge clk); adv_valid = 1'b1; adv_len = 16'h0020;
    @(negedge clk); adv_valid = 1'b0;
    rd(2'd1, 32'h0000_1020, "R10 advance");
    @(negedge clk); adv_valid = 1'b1; adv_len = 16'hFFFF;
    @(negedge clk); adv_valid = 1'b0;
    rd(2'd1, 32'h0001_101F, "R10 large advance");
    @(negedge clk);
    adv_valid = 1'b1; adv_len = 16'h0004;
    wr_en = 1'b1; bus_addr = 4'h4; wdata = 32'h0000_2000;
    @(negedge clk);
    adv_valid = 1'b0; wr_en = 1'b0;
    rd(2'd1, 32'h0000_2000, "R10 write beats advance");

    repeat (3) @(negedge clk);
    check("R2 all reads returned", expq.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule